// File: doc/BRIEF.md
# Bus Write-Cycle Qualifier

This block takes the chip-enable, write-enable and output-enable strobes of an asynchronous parallel bus, which arrive active low with no timing relation to the system clock. It turns them into clean write events for the command logic behind it. Each strobe passes through a two-flop synchroniser and a stability filter. A level counts only after it has been seen for `STABLE_N` consecutive clocks, so short noise pulses are dropped.

A write cycle opens when the later of chip-enable and write-enable goes low while output-enable is high. The bus address is captured at that moment. The cycle closes on whichever of chip-enable and write-enable returns high first, and the bus data is captured there. The block then emits a one-clock `wr_valid` pulse carrying the captured address and data.

A power-good input stands for the supply monitor. While it is low, nothing is accepted. After it rises, the block stays disarmed until chip-enable and write-enable have both been seen high. Strobes that were already asserted as power came up therefore cannot produce a command.

Top module: `bus_write_qualifier`

## Requirements
- R1: After reset, `wr_valid` is low and `wr_addr` and `wr_data` are all zeros.
- R2: A complete cycle produces exactly one `wr_valid` pulse, one clock wide. A cycle is both enables low with output-enable high, followed by one enable returning high.
- R3: `wr_addr` carries the address present when the later of the two enable falls is accepted. Any value present at the earlier fall is discarded.
- R4: `wr_data` carries the data present when the first of the two enable rises is accepted. The later rise neither changes it nor produces a second pulse.
- R5: If output-enable is low when the second enable falls, no pulse results. If output-enable falls while a cycle is open, that cycle is dropped without a pulse.
- R6: A low or high excursion on any strobe shorter than `STABLE_N` clocks is ignored. It neither opens, closes nor drops a cycle.
- R7: While `pwr_good` is low, no pulse is produced. A cycle open when `pwr_good` falls is dropped.
- R8: After `pwr_good` rises, no cycle is accepted until chip-enable and write-enable have both been seen high. A write-enable rise that follows power-up with both enables already low yields no pulse.
- R9: A strobe level held for exactly `STABLE_N` clocks is accepted. A write-enable pulse of that width with chip-enable low gives one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supply valid, synchronous to clk |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Bus address |
| data | input | DATA_W | Bus data |
| wr_valid | output | 1 | One-clock pulse per accepted write |
| wr_addr | output | ADDR_W | Address of the last accepted write |
| wr_data | output | DATA_W | Data of the last accepted write |

## Verification
The embedded properties assume `pwr_good` is already synchronous to `clk`. They also assume that successive strobe transitions are spaced well beyond the synchroniser plus filter latency, so one cycle always ends before the next begins. They further rely on address and data staying stable for at least `STABLE_N + 3` clocks after the strobe edge that captures them. The directed stimulus changes inputs only on the falling clock edge and waits eight clocks between strobe transitions. It holds address and data until the capturing edge has settled. Glitches are the only deliberately short transitions.

// File: rtl/bus_write_qualifier.sv
module bus_write_qualifier #(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int STABLE_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int CW = (STABLE_N < 2) ? 1 : $clog2(STABLE_N + 1);
  localparam int CE = 0;
  localparam int WE = 1;
  localparam int OE = 2;

  logic [2:0] s1, s2, filt, commit, nxt;
  logic [CW-1:0] cnt [3];
  logic armed, in_cycle;
  logic [ADDR_W-1:0] addr_q;

  // strobes start as asserted so a pin held low at reset never looks like a fresh fall
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {oe_n, we_n, ce_n};
      s2 <= s1;
    end

  for (genvar i = 0; i < 3; i++) begin : g_filt
    assign commit[i] = (s2[i] != filt[i]) && (cnt[i] == CW'(STABLE_N - 1));
    assign nxt[i]    = commit[i] ? s2[i] : filt[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        filt[i] <= 1'b0;
        cnt[i]  <= '0;
      end else if (s2[i] == filt[i]) begin
        cnt[i] <= '0;
      end else if (commit[i]) begin
        filt[i] <= s2[i];
        cnt[i]  <= '0;
      end else begin
        cnt[i] <= cnt[i] + 1'b1;
      end
  end

  wire en_fall = (commit[CE] && !s2[CE]) || (commit[WE] && !s2[WE]);
  wire en_rise = (commit[CE] &&  s2[CE]) || (commit[WE] &&  s2[WE]);
  wire oe_fall = commit[OE] && !s2[OE];
  wire open_ok = !nxt[CE] && !nxt[WE] && nxt[OE];
  wire start   = pwr_good && armed && !in_cycle && en_fall && open_ok;
  wire finish  = pwr_good && in_cycle && en_rise && !oe_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      armed <= 1'b0;
    else if (!pwr_good)              armed <= 1'b0;
    else if (filt[CE] && filt[WE])   armed <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              in_cycle <= 1'b0;
    else if (!pwr_good)                      in_cycle <= 1'b0;
    else if (start)                          in_cycle <= 1'b1;
    else if (in_cycle && (en_rise || oe_fall)) in_cycle <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      addr_q <= '0;
    else if (start)  addr_q <= addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= finish;
      if (finish) begin
        wr_addr <= addr_q;
        wr_data <= data;
      end
    end

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R7
  pwr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !wr_valid);

  // R8
  arm_before_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_cycle |-> armed);

  // R6
  filt_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> ($past(s2) == filt));

  // R5
  oe_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(filt[OE]));

endmodule

// File: tb/bus_write_qualifier_test.sv
module bus_write_qualifier_test;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int SN = 3;

  logic clk = 0, rst_n = 0, pwr_good = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, failures = 0, pulses = 0, wide = 0;
  logic prev_v = 0;
  logic [AW-1:0] got_a;
  logic [DW-1:0] got_d;

  always #2.5 clk = ~clk;

  bus_write_qualifier #(.ADDR_W(AW), .DATA_W(DW), .STABLE_N(SN)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .data(data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data));

  always @(negedge clk) begin
    if (wr_valid) begin
      pulses++;
      got_a = wr_addr;
      got_d = wr_data;
      if (prev_v) wide++;
    end
    prev_v = wr_valid;
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_case();
    clocks(12);
    pulses = 0;
    wide = 0;
  endtask

  task automatic t_reset();
    clocks(1);
    chk("R1 valid", wr_valid, 0);
    chk("R1 addr", wr_addr, 0);
    chk("R1 data", wr_data, 0);
    rst_n = 1;
    pwr_good = 1;
  endtask

  task automatic t_basic();
    begin_case();
    addr = 19'h1_2345; data = 8'hA5;
    ce_n = 0; clocks(8);
    we_n = 0; clocks(8);
    we_n = 1; clocks(8);
    ce_n = 1; clocks(8);
    chk("R2 count", pulses, 1);
    chk("R2 width", wide, 0);
    chk("R2 addr", got_a, 19'h1_2345);
    chk("R2 data", got_d, 8'hA5);
  endtask

  task automatic t_addr_later();
    begin_case();
    addr = 19'h0_0AAA; data = 8'h3C;
    we_n = 0; clocks(8);
    addr = 19'h7_0F0F;
    ce_n = 0; clocks(8);
    addr = 19'h0_1111;
    ce_n = 1; clocks(8);
    we_n = 1; clocks(8);
    chk("R3 count", pulses, 1);
    chk("R3 addr", got_a, 19'h7_0F0F);
  endtask

  task automatic t_data_first();
    begin_case();
    addr = 19'h2_0000; data = 8'h11;
    ce_n = 0; clocks(8);
    we_n = 0; clocks(8);
    ce_n = 1; clocks(8);
    data = 8'hEE;
    we_n = 1; clocks(8);
    chk("R4 count", pulses, 1);
    chk("R4 data", got_d, 8'h11);
  endtask

  task automatic t_oe();
    begin_case();
    oe_n = 0; clocks(8);
    ce_n = 0; clocks(8);
    we_n = 0; clocks(8);
    oe_n = 1; clocks(8);
    we_n = 1; clocks(8);
    ce_n = 1; clocks(8);
    chk("R5 oe low at open", pulses, 0);
    ce_n = 0; clocks(8);
    we_n = 0; clocks(8);
    oe_n = 0; clocks(8);
    we_n = 1; clocks(8);
    ce_n = 1; oe_n = 1; clocks(8);
    chk("R5 oe fall aborts", pulses, 0);
  endtask

  task automatic t_glitch();
    begin_case();
    ce_n = 0; clocks(8);
    we_n = 0; clocks(SN - 1);
    we_n = 1; clocks(8);
    ce_n = 1; clocks(8);
    chk("R6 we glitch", pulses, 0);
    we_n = 0; clocks(8);
    ce_n = 0; clocks(SN - 1);
    ce_n = 1; clocks(8);
    we_n = 1; clocks(8);
    chk("R6 ce glitch", pulses, 0);
    data = 8'h5A;
    ce_n = 0; clocks(8);
    we_n = 0; clocks(8);
    oe_n = 0; clocks(SN - 1);
    oe_n = 1; clocks(8);
    we_n = 1; clocks(8);
    ce_n = 1; clocks(8);
    chk("R6 oe glitch keeps cycle", pulses, 1);
    chk("R6 oe glitch data", got_d, 8'h5A);
  endtask

  task automatic t_min_width();
    begin_case();
    data = 8'hC3;
    ce_n = 0; clocks(8);
    we_n = 0; clocks(SN);
    we_n = 1; clocks(8);
    ce_n = 1; clocks(8);
    chk("R9 min width count", pulses, 1);
    chk("R9 min width data", got_d, 8'hC3);
  endtask

  task automatic t_power();
    begin_case();
    pwr_good = 0; clocks(4);
    ce_n = 0; clocks(8);
    we_n = 0; clocks(8);
    we_n = 1; clocks(8);
    ce_n = 1; clocks(8);
    chk("R7 no write while low", pulses, 0);
    pwr_good = 1; clocks(8);
    ce_n = 0; clocks(8);
    we_n = 0; clocks(8);
    pwr_good = 0; clocks(4);
    pwr_good = 1; clocks(4);
    we_n = 1; clocks(8);
    ce_n = 1; clocks(8);
    chk("R7 drop mid cycle", pulses, 0);
  endtask

  task automatic t_lockout();
    begin_case();
    pwr_good = 0; clocks(4);
    ce_n = 0; we_n = 0; oe_n = 1; clocks(8);
    pwr_good = 1; clocks(8);
    we_n = 1; clocks(8);
    we_n = 0; clocks(8);
    we_n = 1; clocks(8);
    chk("R8 locked out", pulses, 0);
    ce_n = 1; clocks(8);
    data = 8'h77; addr = 19'h5_5555;
    ce_n = 0; clocks(8);
    we_n = 0; clocks(8);
    we_n = 1; clocks(8);
    ce_n = 1; clocks(8);
    chk("R8 armed after idle", pulses, 1);
    chk("R8 addr", got_a, 19'h5_5555);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_addr_later();
    t_data_first();
    t_oe();
    t_glitch();
    t_min_width();
    t_power();
    t_lockout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule